// File: doc/BRIEF.md
# Serial-EEPROM Command Proxy Register

This block is a small memory-mapped register set. It lets a host read the identification EEPROMs of up to three interface-card slots through plain register accesses, so the host never has to toggle the serial lines itself. The host first writes a 16-bit select code, which names one slot or none. It then writes two command words to a data port and reads one 16-bit result back from the same port. A separate presence register shows which slots hold a card that carries an EEPROM.

Each slot's EEPROM holds 64 bytes. The contents are kept in a per-slot byte array that is loaded through a backdoor write port. The first command word carries a read opcode and a 6-bit byte address, and only the address bits are used. The result packs the addressed byte in the upper half and the next byte, wrapping modulo 64, in the lower half.

A result can be read only once. A read returns all ones when no command is pending, when no slot is selected, or when the selected slot has no card. Read data leaves on a response stream made of `rsp_valid` and `rsp_data`. That stream has no ready: one response is produced for every accepted read, exactly one cycle later, and the host must take it in that cycle, so it cannot apply back-pressure. The host must not assert `host_wr` and `host_rd` in the same cycle.

Top module: `eeprom_cmd_proxy`

## Requirements
- R1: A write to offset 0x12 stores a 16-bit select code. 0x1700 selects slot 0, 0x1D00 selects slot 1 and 0x3500 selects slot 2. Every other value, near misses included, selects no slot.
- R2: A read of offset 0x12 returns 0xFFFF with bit n (n = 0..2) cleared when `card_present[n]` is 1.
- R3: Writes to offset 0x42 fill a two-entry command buffer. After the second word the command is valid and the write pointer wraps to 0. A single word does not make the command valid.
- R4: The result address is bits [5:0] of the first command word, and all higher bits are ignored. A valid read returns the byte at that address in bits [15:8] and the byte at (address+1) mod 64 in bits [7:0].
- R5: A read of offset 0x42 clears the valid flag, so a second read without new commands returns 0xFFFF.
- R6: A read of offset 0x42 with no valid command returns 0xFFFF.
- R7: A valid command returns 0xFFFF when no slot is selected or when the selected slot's `card_present` bit is 0. The read still consumes the command.
- R8: After reset the select register, the command pointer and the valid flag are all zero. Writing a select code does not move the command pointer.
- R9: Every read produces `rsp_valid` high for exactly one cycle, in the cycle after `host_rd`, with the data on `rsp_data`. No read means no response.
- R10: A read of any other offset returns 0x0000, and writes to other offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after `host_rd` |
| rsp_data | output | 16 | Read response data |
| card_present | input | 3 | Per-slot card-with-EEPROM present |
| img_we | input | 1 | Backdoor image write enable |
| img_slot | input | 2 | Backdoor slot index |
| img_addr | input | 6 | Backdoor byte address |
| img_data | input | 8 | Backdoor byte data |

## Verification
The bench builds the block with its default parameters: three slots of 64 bytes and a 16-bit data word. At that size every byte address of every slot can be swept, so the modulo-64 wrap at address 63 and the masking of high command bits are reached for all three slots. All eight presence patterns are driven, and select codes are tried both exact and off by one bit. The expected image bytes come from an arithmetic formula over the slot and the address.

// File: rtl/eeprom_proxy_pkg.sv
package eeprom_proxy_pkg;
  localparam int NUM_SLOTS  = 3;
  localparam int IMG_AW     = 6;
  localparam int DATA_W     = 16;
  localparam int REG_AW     = 8;
  localparam int CMD_WORDS  = 2;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);

  localparam logic [REG_AW-1:0] OFS_SELECT = 8'h12;
  localparam logic [REG_AW-1:0] OFS_DATA   = 8'h42;

  function automatic logic [DATA_W-1:0] slot_code(input int idx);
    case (idx)
      0:       slot_code = 16'h1700;
      1:       slot_code = 16'h1D00;
      2:       slot_code = 16'h3500;
      default: slot_code = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/eeprom_slot_decode.sv
module eeprom_slot_decode
  import eeprom_proxy_pkg::*;
#(
  parameter int NSLOT = NUM_SLOTS,
  parameter int DW    = DATA_W,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [DW-1:0]    sel_code,
  output logic [NSLOT-1:0] sel_hit,
  output logic [SW-1:0]    sel_idx
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign sel_hit[s] = (sel_code == slot_code(s));
  end

  always_comb begin
    sel_idx = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (sel_hit[s]) sel_idx = SW'(s);
    end
  end
endmodule

// File: rtl/eeprom_cmd_buf.sv
module eeprom_cmd_buf #(
  parameter int DW    = 16,
  parameter int WORDS = 2,
  localparam int PW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] word,
  input  logic          consume,
  output logic          cmd_valid,
  output logic [PW-1:0] cmd_ptr,
  output logic [DW-1:0] first_word
);
  logic [DW-1:0] words_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ptr   <= '0;
      cmd_valid <= 1'b0;
      for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
    end else if (push) begin
      words_q[cmd_ptr] <= word;
      if (cmd_ptr == PW'(WORDS-1)) begin
        cmd_ptr   <= '0;
        cmd_valid <= 1'b1;
      end else begin
        cmd_ptr <= cmd_ptr + 1'b1;
      end
    end else if (consume) begin
      cmd_valid <= 1'b0;
    end
  end

  assign first_word = words_q[0];
endmodule

// File: rtl/eeprom_image.sv
module eeprom_image #(
  parameter int NSLOT = 3,
  parameter int AW    = 6,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wr_slot,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [SW-1:0] rd_slot,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    hi_byte,
  output logic [7:0]    lo_byte
);
  logic [7:0]    hi_by_slot [NSLOT];
  logic [7:0]    lo_by_slot [NSLOT];
  logic [AW-1:0] next_addr;

  assign next_addr = rd_addr + 1'b1;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wr_slot == SW'(s)) mem[wr_addr] <= wr_data;
    end
    assign hi_by_slot[s] = mem[rd_addr];
    assign lo_by_slot[s] = mem[next_addr];
  end

  always_comb begin
    hi_byte = 8'hFF;
    lo_byte = 8'hFF;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_slot == SW'(s)) begin
        hi_byte = hi_by_slot[s];
        lo_byte = lo_by_slot[s];
      end
    end
  end
endmodule

// File: rtl/eeprom_cmd_proxy.sv
module eeprom_cmd_proxy
  import eeprom_proxy_pkg::*;
#(
  parameter int NSLOT = NUM_SLOTS,
  parameter int AW    = IMG_AW,
  parameter int DW    = DATA_W,
  parameter int RAW   = REG_AW,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int PW   = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [RAW-1:0]   host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  input  logic [NSLOT-1:0] card_present,
  input  logic             img_we,
  input  logic [SW-1:0]    img_slot,
  input  logic [AW-1:0]    img_addr,
  input  logic [7:0]       img_data
);
  logic [DW-1:0]    sel_q;
  logic [NSLOT-1:0] sel_hit;
  logic [SW-1:0]    sel_idx;
  logic             cmd_valid;
  logic [PW-1:0]    cmd_ptr;
  logic [DW-1:0]    first_word;
  logic [7:0]       hi_byte, lo_byte;
  logic             wr_sel, wr_data, rd_sel, rd_data;
  logic             slot_ok;
  logic [DW-1:0]    pres_word, data_word;

  assign wr_sel  = host_wr && host_addr == OFS_SELECT;
  assign wr_data = host_wr && host_addr == OFS_DATA;
  assign rd_sel  = host_rd && host_addr == OFS_SELECT;
  assign rd_data = host_rd && host_addr == OFS_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_sel) sel_q <= host_wdata;
  end

  eeprom_slot_decode #(.NSLOT(NSLOT), .DW(DW)) u_dec (
    .sel_code (sel_q),
    .sel_hit  (sel_hit),
    .sel_idx  (sel_idx)
  );

  eeprom_cmd_buf #(.DW(DW), .WORDS(CMD_WORDS)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_data),
    .word       (host_wdata),
    .consume    (rd_data),
    .cmd_valid  (cmd_valid),
    .cmd_ptr    (cmd_ptr),
    .first_word (first_word)
  );

  eeprom_image #(.NSLOT(NSLOT), .AW(AW)) u_img (
    .clk     (clk),
    .we      (img_we),
    .wr_slot (img_slot),
    .wr_addr (img_addr),
    .wr_data (img_data),
    .rd_slot (sel_idx),
    .rd_addr (first_word[AW-1:0]),
    .hi_byte (hi_byte),
    .lo_byte (lo_byte)
  );

  assign slot_ok = (|sel_hit) && card_present[sel_idx];

  always_comb begin
    pres_word = '1;
    pres_word[NSLOT-1:0] = ~card_present;
  end

  assign data_word = (cmd_valid && slot_ok) ? DW'({hi_byte, lo_byte}) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= host_rd;
      if (rd_sel)       rsp_data <= pres_word;
      else if (rd_data) rsp_data <= data_word;
      else if (host_rd) rsp_data <= '0;
    end
  end
endmodule

// File: rtl/eeprom_cmd_proxy_chk.sv
module eeprom_cmd_proxy_chk
  import eeprom_proxy_pkg::*;
#(
  parameter int NSLOT = NUM_SLOTS,
  parameter int DW    = DATA_W,
  parameter int RAW   = REG_AW,
  parameter int PW    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [RAW-1:0]   host_addr,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_data,
  input logic [NSLOT-1:0] card_present,
  input logic             cmd_valid,
  input logic [PW-1:0]    cmd_ptr
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !rsp_valid); // R9
  AST_SECOND_WORD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA && cmd_ptr == PW'(CMD_WORDS-1)) |=> (cmd_valid && cmd_ptr == '0)); // R3
  AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFS_DATA) |=> !cmd_valid); // R5
  AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFS_DATA && !cmd_valid) |=> rsp_data == '1); // R6
  AST_PRESENCE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFS_SELECT) |=>
      (rsp_data[NSLOT-1:0] == ~$past(card_present) && &rsp_data[DW-1:NSLOT])); // R2
  AST_SELECT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_SELECT) |=> $stable(cmd_ptr)); // R8
  AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_rd)); // R9
endmodule

bind eeprom_cmd_proxy eeprom_cmd_proxy_chk #(
  .NSLOT(NSLOT), .DW(DW), .RAW(RAW), .PW(PW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_addr    (host_addr),
  .rsp_valid    (rsp_valid),
  .rsp_data     (rsp_data),
  .card_present (card_present),
  .cmd_valid    (cmd_valid),
  .cmd_ptr      (cmd_ptr)
);

// File: tb/eeprom_cmd_proxy_tb.sv
module eeprom_cmd_proxy_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [2:0]  card_present = 3'b000;
  logic        img_we = 1'b0;
  logic [1:0]  img_slot = '0;
  logic [5:0]  img_addr = '0;
  logic [7:0]  img_data = '0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] rd_val;

  always #2.5 clk = ~clk;

  eeprom_cmd_proxy u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .card_present(card_present), .img_we(img_we),
    .img_slot(img_slot), .img_addr(img_addr), .img_data(img_data)
  );

  function automatic logic [7:0] img_byte(input int s, input int a);
    return 8'(((s * 64 + a) * 37) + 11);
  endfunction

  function automatic logic [15:0] code_of(input int s);
    case (s)
      0: return 16'h1700;
      1: return 16'h1D00;
      default: return 16'h3500;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = rsp_data;
    check("R9 rsp_valid", {15'd0, rsp_valid}, 16'd1);
  endtask

  task automatic issue_cmd(input logic [15:0] w0);
    bus_write(8'h42, w0);
    bus_write(8'h42, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // load images through backdoor
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 64; a++) begin
        @(negedge clk);
        img_we = 1'b1; img_slot = 2'(s); img_addr = 6'(a); img_data = img_byte(s, a);
      end
    end
    @(negedge clk);
    img_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 no rsp without read", {15'd0, rsp_valid}, 16'd0);

    // R8 reset state: nothing pending, no slot
    card_present = 3'b111;
    bus_read(8'h42, rd_val); check("R8 reset no command", rd_val, 16'hFFFF);
    // one word after reset is not a command (ptr was 0), select 0 after reset
    bus_write(8'h42, 16'h0185);
    bus_read(8'h42, rd_val); check("R3 single word not valid", rd_val, 16'hFFFF);
    bus_write(8'h42, 16'h0000); // completes command, no slot selected
    bus_read(8'h42, rd_val); check("R7 no slot selected", rd_val, 16'hFFFF);

    // R2 presence sweep
    for (int p = 0; p < 8; p++) begin
      card_present = 3'(p);
      bus_read(8'h12, rd_val);
      check("R2 presence", rd_val, 16'hFFFF & ~16'(p));
    end
    card_present = 3'b111;

    // R4 full sweep with R1 exact codes
    for (int s = 0; s < 3; s++) begin
      bus_write(8'h12, code_of(s));
      for (int a = 0; a < 64; a++) begin
        issue_cmd(((a % 2) == 1 ? 16'hFFC0 : 16'h0180) | 16'(a));
        bus_read(8'h42, rd_val);
        check("R4 R1 slot data", rd_val, {img_byte(s, a), img_byte(s, (a + 1) % 64)});
      end
      bus_read(8'h42, rd_val); check("R5 second read", rd_val, 16'hFFFF);
    end

    // R1 near-miss codes select nothing
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 16; b += 5) begin
        bus_write(8'h12, code_of(s) ^ (16'h1 << b));
        issue_cmd(16'h0182);
        bus_read(8'h42, rd_val);
        check("R1 near miss", rd_val, 16'hFFFF);
      end
    end

    // R7 absent card, R5 command consumed
    bus_write(8'h12, 16'h1D00);
    card_present = 3'b101;
    issue_cmd(16'h0190);
    bus_read(8'h42, rd_val); check("R7 absent card", rd_val, 16'hFFFF);
    card_present = 3'b111;
    bus_read(8'h42, rd_val); check("R7 command consumed", rd_val, 16'hFFFF);

    // R8 select write between command words keeps pointer
    bus_write(8'h42, 16'h01BF);
    bus_write(8'h12, 16'h3500);
    bus_write(8'h42, 16'h0000);
    bus_read(8'h42, rd_val); check("R8 ptr kept", rd_val, {img_byte(2, 63), img_byte(2, 0)});

    // R10 other offsets
    bus_write(8'h20, 16'h1700);
    bus_write(8'h40, 16'h0181);
    bus_read(8'h42, rd_val); check("R10 writes ignored (no cmd)", rd_val, 16'hFFFF);
    bus_read(8'h20, rd_val); check("R10 unmapped read", rd_val, 16'h0000);
    issue_cmd(16'h0181);
    bus_read(8'h42, rd_val); check("R10 select unchanged", rd_val, {img_byte(2, 1), img_byte(2, 2)});

    // R3 third word starts new command; valid kept until read
    issue_cmd(16'h0104);
    bus_write(8'h42, 16'h0107);
    bus_read(8'h42, rd_val); check("R3 valid held", rd_val, {img_byte(2, 7), img_byte(2, 8)});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule